// File: doc/BRIEF.md
# Attenuator Control Word Selector

This block produces the 7-bit control word of a digital step attenuator. The word comes either from seven parallel control inputs or from the word that a serial loader has assembled. A single select input picks the source. In parallel operation, the level of the latch-enable input picks the style. With latch enable held high the pins pass straight through (direct). With latch enable low the pins are ignored until the strobe falls (latched). In serial operation the same strobe commits the loader's word, but only when the loader reports that its address matched.

After reset the word sits at maximum attenuation. In serial and latched operation it stays there until the first commit. In direct operation it stays there for a programmable number of clock cycles and then follows the pins. The serial shifter and the address compare belong to the loader and are outside this block. The latch enable and the other control inputs are expected to arrive already synchronous to `clk`.

Top module: `atten_ctrl_select`

## Requirements
- R1: `ser_sel_i` low selects the parallel pins and high selects the serial loader. While it is high, `par_word_i` and a steady high `latch_en_i` leave `atten_o` unchanged.
- R2: Bit k of the word weighs 0.25·2^k dB, bit 0 being the finest step. The word equals four times the attenuation in dB: 7'h7F is 31.75 dB, 7'h00 is the reference insertion-loss state, and 18.25 dB is 7'h49.
- R3: In direct operation (`ser_sel_i`=0, `latch_en_i`=1, power-up delay over), `atten_o` equals the `par_word_i` value sampled at the previous clock edge.
- R4: In parallel operation, a falling `latch_en_i` (high at one edge, low at the next) loads the `par_word_i` value present at the edge that sees it low. While `latch_en_i` stays low, changes on `par_word_i` leave `atten_o` unchanged.
- R5: Once reset is released, `atten_o` is 7'h7F and stays 7'h7F in serial and latched operation until a commit event.
- R6: In direct operation, `atten_o` is forced to 7'h7F until `PWRUP_CYCLES` clocks have passed after the internal reset release. From then on it follows the pins.
- R7: In serial operation, a falling `latch_en_i` with `ser_hit_i` high loads `ser_word_i`. With `ser_hit_i` low the same strobe leaves `atten_o` unchanged.
- R8: Parallel pins that all read low in direct operation give minimum attenuation (7'h00) once the delay is over.
- R9: A change of `ser_sel_i` alone does not change `atten_o`. Only the next commit event in the new mode changes it; in direct operation after the delay, the pins take effect at once.
- R10: When `ser_sel_i` and a falling `latch_en_i` change in the same cycle, the select value of that cycle picks the source that the strobe loads.
- R11: Once the power-up delay has expired it stays expired until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_i | input | 1 | Source select: 0 parallel, 1 serial |
| latch_en_i | input | 1 | Latch enable / commit strobe |
| par_word_i | input | 7 | Parallel control pins |
| ser_word_i | input | 7 | Attenuation word from the serial loader |
| ser_hit_i | input | 1 | Loader address matched |
| atten_o | output | 7 | Attenuator control word |

## Verification
Two functions can meet in the same cycle: the source switch and the commit strobe. They do so when `ser_sel_i` flips at the same edge where `latch_en_i` first reads low. The bench drives both changes at one falling clock edge, in both directions. It expects the word from the newly selected source one cycle later and not the other source's value. A second coincidence is also covered: direct operation reaching the end of the power-up delay while the pins hold a preset. The bench judges this by sampling well before and well after the expiry.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;

  localparam int unsigned ATT_W_DEF = 7;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_SER  = 2'd2,
    SRC_MAX  = 2'd3
  } att_src_e;

endpackage

// File: rtl/atten_rst_sync.sv
module atten_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/atten_pwrup_timer.sv
module atten_pwrup_timer #(
  parameter int unsigned PWRUP_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWRUP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             done_q;
  logic             done_nxt;
  logic             cnt_en;

  assign cnt_en = !done_q;

  always_comb begin
    cnt_nxt  = cnt_q + 1'b1;
    done_nxt = (cnt_q == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_nxt;
      done_q <= done_nxt;
    end
  end

  assign done_o = done_q;

  AST_DELAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q) else $error("power-up delay flag dropped"); // R11

endmodule

// File: rtl/atten_strobe_det.sv
module atten_strobe_det (
  input  logic clk,
  input  logic rst_n,
  input  logic le_i,
  output logic le_fall_o
);

  logic le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q <= 1'b0;
    end else begin
      le_q <= le_i;
    end
  end

  assign le_fall_o = le_q && !le_i;

endmodule

// File: rtl/atten_word_sel.sv
module atten_word_sel
  import atten_ctrl_pkg::*;
#(
  parameter int unsigned ATT_W = ATT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_sel_i,
  input  logic             le_lvl_i,
  input  logic             le_fall_i,
  input  logic             pwrup_done_i,
  input  logic [ATT_W-1:0] par_word_i,
  input  logic [ATT_W-1:0] ser_word_i,
  input  logic             ser_hit_i,
  output logic [ATT_W-1:0] att_o
);

  localparam logic [ATT_W-1:0] ATT_MAX = {ATT_W{1'b1}};

  att_src_e         src;
  logic [ATT_W-1:0] att_q;
  logic [ATT_W-1:0] att_nxt;
  logic             att_en;

  // Source decision: serial commits need a strobe and a hit; parallel
  // commits on a strobe, or continuously while latch enable is high.
  always_comb begin
    src = SRC_HOLD;
    if (ser_sel_i) begin
      if (le_fall_i && ser_hit_i) begin
        src = SRC_SER;
      end
    end else if (le_fall_i) begin
      src = SRC_PAR;
    end else if (le_lvl_i) begin
      src = pwrup_done_i ? SRC_PAR : SRC_MAX;
    end
  end

  always_comb begin
    unique case (src)
      SRC_PAR: att_nxt = par_word_i;
      SRC_SER: att_nxt = ser_word_i;
      SRC_MAX: att_nxt = ATT_MAX;
      default: att_nxt = att_q;
    endcase
    att_en = (src != SRC_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q <= ATT_MAX;
    end else if (att_en) begin
      att_q <= att_nxt;
    end
  end

  assign att_o = att_q;

  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel_i && le_lvl_i && pwrup_done_i) |=> (att_q == $past(par_word_i)))
    else $error("direct word mismatch"); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel_i && !le_lvl_i && !le_fall_i) |=> $stable(att_q))
    else $error("latched word moved without strobe"); // R4

  AST_PWRUP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel_i && le_lvl_i && !pwrup_done_i) |=> (att_q == ATT_MAX))
    else $error("direct word released before delay"); // R6

  AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel_i && le_fall_i && ser_hit_i) |=> (att_q == $past(ser_word_i)))
    else $error("serial commit mismatch"); // R7

  AST_SER_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel_i && !(le_fall_i && ser_hit_i)) |=> $stable(att_q))
    else $error("serial word moved without valid commit"); // R1

endmodule

// File: rtl/atten_ctrl_select.sv
module atten_ctrl_select
  import atten_ctrl_pkg::*;
#(
  parameter int unsigned ATT_W        = ATT_W_DEF,
  parameter int unsigned PWRUP_CYCLES = 20000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_sel_i,
  input  logic             latch_en_i,
  input  logic [ATT_W-1:0] par_word_i,
  input  logic [ATT_W-1:0] ser_word_i,
  input  logic             ser_hit_i,
  output logic [ATT_W-1:0] atten_o
);

  logic rst_sync_n;
  logic le_fall;
  logic pwrup_done;

  atten_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  atten_pwrup_timer #(
    .PWRUP_CYCLES(PWRUP_CYCLES)
  ) u_pwrup_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .done_o(pwrup_done)
  );

  atten_strobe_det u_strobe_det (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .le_i     (latch_en_i),
    .le_fall_o(le_fall)
  );

  atten_word_sel #(
    .ATT_W(ATT_W)
  ) u_word_sel (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ser_sel_i   (ser_sel_i),
    .le_lvl_i    (latch_en_i),
    .le_fall_i   (le_fall),
    .pwrup_done_i(pwrup_done),
    .par_word_i  (par_word_i),
    .ser_word_i  (ser_word_i),
    .ser_hit_i   (ser_hit_i),
    .att_o       (atten_o)
  );

  AST_RESET_MAX: assert property (@(posedge clk)
    (!rst_sync_n) |=> (!rst_sync_n || atten_o == {ATT_W{1'b1}}))
    else $error("word not at maximum out of reset"); // R5

endmodule

// File: tb/atten_ctrl_select_tb.sv
module atten_ctrl_select_tb;

  localparam int unsigned W     = 7;
  localparam int unsigned DELAY = 40;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ser_sel;
  logic         le;
  logic [W-1:0] par_w;
  logic [W-1:0] ser_w;
  logic         hit;
  logic [W-1:0] atten;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  atten_ctrl_select #(
    .ATT_W(W),
    .PWRUP_CYCLES(DELAY)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_sel_i (ser_sel),
    .latch_en_i(le),
    .par_word_i(par_w),
    .ser_word_i(ser_w),
    .ser_hit_i (hit),
    .atten_o   (atten)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [W-1:0] exp, input string req);
    n_chk++;
    if (atten !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, atten, exp);
    end
  endtask

  task automatic do_reset(input logic sel, input logic le_v, input logic [W-1:0] pins);
    @(negedge clk);
    rst_n   = 1'b0;
    ser_sel = sel;
    le      = le_v;
    par_w   = pins;
    ser_w   = '0;
    hit     = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic strobe();
    le = 1'b1;
    tick(1);
    le = 1'b0;
    tick(1);
  endtask

  // R5 R6 R8: direct mode with low pins holds max through the delay
  task automatic t_direct_pwrup();
    do_reset(1'b0, 1'b1, 7'h00);
    tick(1);
    check(7'h7F, "R5 reset value");
    tick(19);
    check(7'h7F, "R6 max during delay");
    tick(40);
    check(7'h00, "R8 low pins give minimum");
    par_w = 7'h2A;
    tick(1);
    check(7'h2A, "R3 direct follow");
    par_w = 7'h55;
    tick(1);
    check(7'h55, "R3 direct follow second pattern");
    tick(300);
    par_w = 7'h0F;
    tick(1);
    check(7'h0F, "R11 delay stays expired");
  endtask

  // R5 R4: latched mode stays at max beyond the delay until a strobe
  task automatic t_latched();
    do_reset(1'b0, 1'b0, 7'h11);
    tick(80);
    check(7'h7F, "R5 latched waits for strobe");
    strobe();
    check(7'h11, "R4 strobe captures pins");
    par_w = 7'h03;
    tick(5);
    check(7'h11, "R4 pins ignored while strobe low");
  endtask

  // R2: single weights and a mixed value, word = dB * 4
  task automatic t_weights();
    for (int k = 0; k < W; k++) begin
      real db;
      db = 0.25 * real'(1 << k);
      par_w = W'(1 << k);
      strobe();
      check(W'(int'(db * 4.0)), $sformatf("R2 weight bit %0d", k));
    end
    par_w = W'(int'(18.25 * 4.0));
    strobe();
    check(7'h49, "R2 18.25 dB word");
  endtask

  // R1 R7: serial commits need a hit; parallel pins and LE level ignored
  task automatic t_serial();
    ser_sel = 1'b1;
    tick(2);
    check(7'h49, "R9 select change alone holds word");
    ser_w = 7'h33;
    hit   = 1'b1;
    strobe();
    check(7'h33, "R7 serial commit with hit");
    ser_w = 7'h44;
    hit   = 1'b0;
    strobe();
    check(7'h33, "R7 serial strobe without hit ignored");
    le    = 1'b1;
    par_w = 7'h01;
    tick(3);
    check(7'h33, "R1 serial ignores pins and direct level");
    le = 1'b0;
    tick(1);
    check(7'h33, "R7 no hit on this strobe");
  endtask

  // R9 R10: mode change and strobe in the same cycle
  task automatic t_coincide();
    ser_sel = 1'b1;
    le      = 1'b1;
    hit     = 1'b1;
    ser_w   = 7'h66;
    par_w   = 7'h19;
    tick(2);
    check(7'h33, "R1 serial level high no effect");
    ser_sel = 1'b0;
    le      = 1'b0;
    tick(1);
    check(7'h19, "R10 strobe with switch to parallel loads pins");
    le = 1'b1;
    tick(1);
    ser_sel = 1'b1;
    le      = 1'b0;
    tick(1);
    check(7'h66, "R10 strobe with switch to serial loads loader word");
    ser_sel = 1'b0;
    tick(3);
    check(7'h66, "R9 switch to latched holds word");
    le    = 1'b1;
    par_w = 7'h7E;
    tick(1);
    check(7'h7E, "R9 switch to direct follows pins at once");
  endtask

  // R7 R5: serial commit allowed inside the delay
  task automatic t_serial_early();
    do_reset(1'b1, 1'b0, 7'h00);
    tick(3);
    ser_w = 7'h05;
    hit   = 1'b1;
    strobe();
    check(7'h05, "R7 serial commit during delay");
  endtask

  initial begin
    rst_n   = 1'b0;
    ser_sel = 1'b0;
    le      = 1'b0;
    par_w   = '0;
    ser_w   = '0;
    hit     = 1'b0;
    t_direct_pwrup();
    t_latched();
    t_weights();
    t_serial();
    t_coincide();
    t_serial_early();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule